// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block is the host side of an external memory port whose address and data share one 16-bit bus. A single request on the internal side (read or write, chip-select index, address, write data) becomes one asynchronous bus access. The controller drives the address during an address-valid strobe, then either releases the bus and pulses the output enable to read, or keeps driving the write data and pulses the write enable. Each access is a chain of segments, and each segment lasts a programmed number of whole clock cycles.

Every chip select has its own timing word. The word sets an address-hold extension, an address-to-read gap, read and write hold segments, read and write wait counts and delta latencies, and a recovery count. The recovery count inserts idle cycles after a read, but only when the next access goes to another chip select or is a write. The controller takes one request at a time. Completion is a one-cycle pulse that carries the captured read data.

Top module: `admux_bus_ctrl`

## Requirements
- R1: During and after reset, all chip selects, the address strobe, the read strobe and the write strobe are high, the bus is not driven, `req_ready` is 1 and `done` is 0.
- R2: Every access opens with exactly one cycle in which `bus_adv_n` is low, the selected chip select is low and the request address is on `bus_ad_out` with `bus_ad_oe` high. The address stays driven for 1 + ah cycles in total.
- R3: On a read, `bus_oe_n` falls 1 + ah + gap + rd_hold cycles after the chip select falls. The bus is released (`bus_ad_oe` low) from the end of the address cycles until the access ends. The chip select rises on the same edge as `bus_oe_n`.
- R4: A strobe (`bus_oe_n` on reads, `bus_we_n` on writes) stays low for wait + delta cycles of the matching direction. When that sum is 0, it stays low for 1 cycle.
- R5: On a write, `bus_we_n` falls right after the 1 + ah address cycles. The write data is driven from then until the chip select rises. The chip select stays low for wr_hold cycles after `bus_we_n` rises.
- R6: After a read, an access that targets a different chip select, or that is a write, keeps all chip selects high for the read's chip-select recovery count. These cycles start at the edge that accepts the request.
- R7: No recovery cycles follow a write, and none separate two reads on the same chip select. The chip select falls on the edge that accepts the request.
- R8: Read data is sampled from `bus_ad_in` on the edge where `bus_oe_n` rises. It is presented on `rdata` with `done`, a pulse that lasts one cycle. That cycle is the first cycle in which all chip selects are high again.
- R9: `req_ready` is 0 from the accepting edge until the `done` cycle. It is 1 in the `done` cycle, so a new request can be accepted there.
- R10: Writing `cfg_wdata` with `cfg_we` at index `cfg_sel` sets that chip select's timing word and no other. Field layout: [0] ah, [2:1] gap, [6:3] rd_hold, [10:7] wr_hold, [14:11] rd_wait, [18:15] wr_wait, [26:19] rd_delta, [34:27] wr_delta, [38:35] recovery. The reset word has recovery 3, rd_delta 12, wr_delta 15 and every other field 0. The word is taken when the request is accepted.
- R11: At most one chip select is low at any time. During an access, the low one is bit `req_cs` of `bus_cs_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all segments count its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | CSW | Chip-select index |
| req_addr | input | DW | Address placed on the bus |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Idle; a valid request is taken at the next edge |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Captured read data |
| cfg_we | input | 1 | Timing word write enable |
| cfg_sel | input | CSW | Chip select whose word is written |
| cfg_wdata | input | 39 | Timing word |
| bus_cs_n | output | NCS | Active-low chip selects |
| bus_adv_n | output | 1 | Active-low address-valid strobe |
| bus_oe_n | output | 1 | Active-low read strobe |
| bus_we_n | output | 1 | Active-low write strobe |
| bus_ad_out | output | DW | Value driven on the shared bus |
| bus_ad_oe | output | 1 | Bus drive enable |
| bus_ad_in | input | DW | Value returned from the shared bus |

## Verification
All bus pins come from registers that are loaded from the next state. They change on the same edge that accepts a request, so the first cycle after acceptance is either recovery or the address cycle. `done` and the read data appear on the edge where the last segment ends, together with the chip select going high. The bench drives on falling edges and samples every pin on each later falling edge. It counts the cycles each condition holds between acceptance and the `done` sample, and compares those counts with values derived from the programmed timing word of that chip select.

// File: rtl/admux_pkg.sv
// Shared types and segment arithmetic for the multiplexed bus controller.
// Assumes one access at a time; every segment length is counted in clk cycles.
package admux_pkg;
    localparam int WAIT_W  = 4;
    localparam int DELTA_W = 8;
    localparam int HOLD_W  = 4;
    localparam int GAP_W   = 2;
    localparam int REC_W   = 4;
    localparam int STRB_W  = $clog2((1 << WAIT_W) + (1 << DELTA_W));

    typedef struct packed {
        logic [REC_W-1:0]   recov;
        logic [DELTA_W-1:0] wr_delta;
        logic [DELTA_W-1:0] rd_delta;
        logic [WAIT_W-1:0]  wr_wait;
        logic [WAIT_W-1:0]  rd_wait;
        logic [HOLD_W-1:0]  wr_hold;
        logic [HOLD_W-1:0]  rd_hold;
        logic [GAP_W-1:0]   gap;
        logic               ah;
    } cs_cfg_t;

    localparam int CFG_W = $bits(cs_cfg_t);

    localparam cs_cfg_t CFG_RESET = '{REC_W'(3), DELTA_W'(15), DELTA_W'(12),
                                      WAIT_W'(0), WAIT_W'(0), HOLD_W'(0),
                                      HOLD_W'(0), GAP_W'(0), 1'b0};

    typedef enum logic [2:0] {
        ST_IDLE, ST_RECOV, ST_ADDR, ST_AHOLD, ST_GAP, ST_STROBE, ST_WHOLD
    } seq_st_t;

    // Segment order of an access, before skipping empty segments.
    function automatic seq_st_t succ(seq_st_t s, logic wr);
        seq_st_t n;
        case (s)
            ST_IDLE:   n = ST_RECOV;
            ST_RECOV:  n = ST_ADDR;
            ST_ADDR:   n = ST_AHOLD;
            ST_AHOLD:  n = wr ? ST_STROBE : ST_GAP;
            ST_GAP:    n = ST_STROBE;
            ST_STROBE: n = wr ? ST_WHOLD : ST_IDLE;
            default:   n = ST_IDLE;
        endcase
        return n;
    endfunction

    // Number of cycles a segment lasts under a given timing word.
    function automatic logic [STRB_W-1:0] seg_len(seq_st_t s, cs_cfg_t c, logic wr,
                                                  logic [REC_W-1:0] rec);
        logic [STRB_W-1:0] n;
        case (s)
            ST_RECOV:  n = STRB_W'(rec);
            ST_ADDR:   n = STRB_W'(1);
            ST_AHOLD:  n = STRB_W'(c.ah);
            ST_GAP:    n = STRB_W'(c.gap) + STRB_W'(c.rd_hold);
            ST_STROBE: begin
                n = wr ? STRB_W'(c.wr_wait) + STRB_W'(c.wr_delta)
                       : STRB_W'(c.rd_wait) + STRB_W'(c.rd_delta);
                if (n == '0) n = STRB_W'(1);
            end
            ST_WHOLD:  n = STRB_W'(c.wr_hold);
            default:   n = '0;
        endcase
        return n;
    endfunction

    // Next non-empty segment after s (the strobe is never empty).
    function automatic seq_st_t walk(seq_st_t s, cs_cfg_t c, logic wr, logic [REC_W-1:0] rec);
        seq_st_t n;
        n = succ(s, wr);
        for (int k = 0; k < 3; k++) begin
            if (n != ST_IDLE && seg_len(n, c, wr, rec) == '0) n = succ(n, wr);
        end
        return n;
    endfunction
endpackage

// File: rtl/admux_cfg_bank.sv
// Per-chip-select timing words with one write port and one read port.
// Assumes cfg_sel and rd_sel are below NCS.
module admux_cfg_bank
    import admux_pkg::*;
#(
    parameter int NCS = 4,
    parameter int CSW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CSW-1:0]   wr_sel,
    input  logic [CFG_W-1:0] wr_data,
    input  logic [CSW-1:0]   rd_sel,
    output cs_cfg_t          rd_cfg
);
    cs_cfg_t cfg_arr [NCS];

    for (genvar g = 0; g < NCS; g++) begin : g_cs
        cs_cfg_t word_q;
        // Hold this chip select's timing word.
        always_ff @(posedge clk) begin
            if (!rst_n)                               word_q <= CFG_RESET;
            else if (wr_en && wr_sel == CSW'(g))      word_q <= cs_cfg_t'(wr_data);
        end
        assign cfg_arr[g] = word_q;
    end

    // Select the word of the requesting chip select.
    always_comb rd_cfg = cfg_arr[rd_sel];
endmodule

// File: rtl/admux_recov_track.sv
// Remembers the previous access and computes the recovery length the next
// access must wait. Recovery only follows a read.
module admux_recov_track
    import admux_pkg::*;
#(
    parameter int CSW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             end_evt,
    input  logic             end_wr,
    input  logic [CSW-1:0]   end_cs,
    input  logic [REC_W-1:0] end_rec,
    input  logic             nxt_wr,
    input  logic [CSW-1:0]   nxt_cs,
    output logic [REC_W-1:0] recov_len
);
    logic             last_rd_q;
    logic [CSW-1:0]   last_cs_q;
    logic [REC_W-1:0] last_rec_q;

    // Record the kind, chip select and recovery count of the access that ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_rd_q  <= 1'b0;
            last_cs_q  <= '0;
            last_rec_q <= '0;
        end else if (end_evt) begin
            last_rd_q  <= !end_wr;
            last_cs_q  <= end_cs;
            last_rec_q <= end_rec;
        end
    end

    // Recovery applies after a read when the chip select changes or a write follows.
    always_comb begin
        recov_len = '0;
        if (last_rd_q && (nxt_cs != last_cs_q || nxt_wr)) recov_len = last_rec_q;
    end
endmodule

// File: rtl/admux_seq.sv
// Access sequencer: walks recovery, address, address hold, read gap, strobe
// and write hold segments. Pin outputs are registered from the next state,
// so they change on the edge that enters a segment.
module admux_seq
    import admux_pkg::*;
#(
    parameter int NCS = 4,
    parameter int CSW = 2,
    parameter int DW  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [CSW-1:0]   req_cs,
    input  logic [DW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  cs_cfg_t          req_cfg,
    input  logic [REC_W-1:0] recov_len,
    output logic             req_ready,
    output logic             done,
    output logic [DW-1:0]    rdata,
    output logic             end_evt,
    output logic             end_wr,
    output logic [CSW-1:0]   end_cs,
    output logic [REC_W-1:0] end_rec,
    output logic [NCS-1:0]   cs_n,
    output logic             adv_n,
    output logic             oe_n,
    output logic             we_n,
    output logic [DW-1:0]    ad_out,
    output logic             ad_oe,
    input  logic [DW-1:0]    ad_in
);
    seq_st_t           st_q, st_d;
    logic [STRB_W-1:0] cnt_q, cnt_d;
    logic              wr_q;
    logic [CSW-1:0]    cs_q;
    logic [DW-1:0]     addr_q, wdata_q;
    cs_cfg_t           cfg_q;

    logic              accept;
    cs_cfg_t           a_cfg;
    logic              a_wr;
    logic [CSW-1:0]    a_cs;
    logic [DW-1:0]     a_addr, a_wdata;
    logic [NCS-1:0]    sel_oh;
    logic              active_d;

    assign accept = (st_q == ST_IDLE) && req_valid;

    // Take request fields in the accepting cycle, latched fields afterwards.
    always_comb begin
        a_cfg   = accept ? req_cfg   : cfg_q;
        a_wr    = accept ? req_write : wr_q;
        a_cs    = accept ? req_cs    : cs_q;
        a_addr  = accept ? req_addr  : addr_q;
        a_wdata = accept ? req_wdata : wdata_q;
    end

    // Next segment and its cycle count.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (st_q == ST_IDLE) begin
            if (req_valid) begin
                st_d  = walk(ST_IDLE, a_cfg, a_wr, recov_len);
                cnt_d = seg_len(st_d, a_cfg, a_wr, recov_len) - STRB_W'(1);
            end
        end else if (cnt_q == '0) begin
            st_d  = walk(st_q, a_cfg, a_wr, recov_len);
            cnt_d = (st_d == ST_IDLE) ? '0
                  : seg_len(st_d, a_cfg, a_wr, recov_len) - STRB_W'(1);
        end else begin
            cnt_d = cnt_q - STRB_W'(1);
        end
    end

    // One-hot of the chip select in use.
    always_comb begin
        sel_oh       = '0;
        sel_oh[a_cs] = 1'b1;
    end

    assign active_d = st_d inside {ST_ADDR, ST_AHOLD, ST_GAP, ST_STROBE, ST_WHOLD};

    // Segment state and counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Latch the request and its timing word on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            cs_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            cfg_q   <= CFG_RESET;
        end else if (accept) begin
            wr_q    <= req_write;
            cs_q    <= req_cs;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            cfg_q   <= req_cfg;
        end
    end

    // Registered bus pins decoded from the next segment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n   <= '1;
            adv_n  <= 1'b1;
            oe_n   <= 1'b1;
            we_n   <= 1'b1;
            ad_out <= '0;
            ad_oe  <= 1'b0;
        end else begin
            cs_n   <= active_d ? ~sel_oh : '1;
            adv_n  <= !(st_d == ST_ADDR);
            oe_n   <= !(st_d == ST_STROBE && !a_wr);
            we_n   <= !(st_d == ST_STROBE && a_wr);
            ad_out <= (st_d inside {ST_ADDR, ST_AHOLD}) ? a_addr : a_wdata;
            ad_oe  <= (st_d inside {ST_ADDR, ST_AHOLD}) ||
                      (a_wr && (st_d inside {ST_STROBE, ST_WHOLD}));
        end
    end

    assign end_evt = (st_q != ST_IDLE) && (st_d == ST_IDLE);
    assign end_wr  = wr_q;
    assign end_cs  = cs_q;
    assign end_rec = cfg_q.recov;

    // Capture read data where the read strobe ends; pulse completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            done  <= 1'b0;
        end else begin
            if (st_q == ST_STROBE && !wr_q && cnt_q == '0) rdata <= ad_in;
            done <= end_evt;
        end
    end

    assign req_ready = (st_q == ST_IDLE);
endmodule

// File: rtl/admux_bus_ctrl.sv
// Top of the multiplexed address/data bus controller: timing word bank,
// recovery tracker and access sequencer. Bus tristate is done outside using
// bus_ad_oe.
module admux_bus_ctrl
    import admux_pkg::*;
#(
    parameter int NCS = 4,
    parameter int DW  = 16,
    localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [CSW-1:0]   req_cs,
    input  logic [DW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             req_ready,
    output logic             done,
    output logic [DW-1:0]    rdata,
    input  logic             cfg_we,
    input  logic [CSW-1:0]   cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [NCS-1:0]   bus_cs_n,
    output logic             bus_adv_n,
    output logic             bus_oe_n,
    output logic             bus_we_n,
    output logic [DW-1:0]    bus_ad_out,
    output logic             bus_ad_oe,
    input  logic [DW-1:0]    bus_ad_in
);
    cs_cfg_t          req_cfg;
    logic [REC_W-1:0] recov_len;
    logic             end_evt, end_wr;
    logic [CSW-1:0]   end_cs;
    logic [REC_W-1:0] end_rec;

    admux_cfg_bank #(.NCS(NCS), .CSW(CSW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_sel(cfg_sel),
        .wr_data(cfg_wdata), .rd_sel(req_cs), .rd_cfg(req_cfg)
    );

    admux_recov_track #(.CSW(CSW)) u_rec (
        .clk(clk), .rst_n(rst_n), .end_evt(end_evt), .end_wr(end_wr),
        .end_cs(end_cs), .end_rec(end_rec), .nxt_wr(req_write),
        .nxt_cs(req_cs), .recov_len(recov_len)
    );

    admux_seq #(.NCS(NCS), .CSW(CSW), .DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_cfg(req_cfg), .recov_len(recov_len), .req_ready(req_ready),
        .done(done), .rdata(rdata), .end_evt(end_evt), .end_wr(end_wr),
        .end_cs(end_cs), .end_rec(end_rec), .cs_n(bus_cs_n),
        .adv_n(bus_adv_n), .oe_n(bus_oe_n), .we_n(bus_we_n),
        .ad_out(bus_ad_out), .ad_oe(bus_ad_oe), .ad_in(bus_ad_in)
    );
endmodule

// File: rtl/admux_bus_ctrl_chk.sv
// Protocol checker for the bus controller pins, bound to the top module.
module admux_bus_ctrl_chk #(
    parameter int NCS = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCS-1:0] cs_n,
    input logic           adv_n,
    input logic           oe_n,
    input logic           we_n,
    input logic           ad_oe,
    input logic           req_ready,
    input logic           done
);
    // R11
    one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    // R2
    adv_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_n |-> (ad_oe && !(&cs_n)));
    // R2
    adv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adv_n) |=> adv_n);
    // R3
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (!ad_oe && we_n));
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((&cs_n) && req_ready));
    // R9
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> ((&cs_n) && adv_n && oe_n && we_n));
endmodule

bind admux_bus_ctrl admux_bus_ctrl_chk #(.NCS(NCS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(bus_cs_n), .adv_n(bus_adv_n),
    .oe_n(bus_oe_n), .we_n(bus_we_n), .ad_oe(bus_ad_oe),
    .req_ready(req_ready), .done(done)
);

// File: tb/sim_admux_bus_ctrl.sv
`timescale 1ns/1ps
// Directed bench: a small device model on the bus, one task per scenario.
module sim_admux_bus_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [1:0]  req_cs, cfg_sel;
    logic [15:0] req_addr, req_wdata, rdata, bus_ad_out, bus_ad_in;
    logic        req_ready, done, cfg_we;
    logic [38:0] cfg_wdata;
    logic [3:0]  bus_cs_n;
    logic        bus_adv_n, bus_oe_n, bus_we_n, bus_ad_oe;

    int vectors = 0, fails = 0;
    bit finished = 0;

    // Expected timing words, per chip select.
    int t_ah[4], t_gap[4], t_rh[4], t_wh[4], t_rw[4], t_ww[4], t_rd[4], t_wd[4], t_rec[4];
    bit last_rd = 0;
    int last_cs = 0;
    logic [15:0] exp_mem [64];
    logic [15:0] dev_mem [64];
    logic [5:0]  dev_addr = '0;

    always #2.5 clk = ~clk;

    admux_bus_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .rdata(rdata), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .bus_cs_n(bus_cs_n),
        .bus_adv_n(bus_adv_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
        .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in)
    );

    function automatic logic [1:0] cs_idx(logic [3:0] v);
        logic [1:0] r = 2'd0;
        for (int i = 0; i < 4; i++) if (!v[i]) r = 2'(i);
        return r;
    endfunction

    // Device model: latch address on the address strobe, store on write strobe.
    always @(negedge clk) begin
        if (!bus_adv_n) dev_addr <= {cs_idx(bus_cs_n), bus_ad_out[3:0]};
        if (!bus_we_n)  dev_mem[dev_addr] <= bus_ad_out;
    end
    assign bus_ad_in = !bus_oe_n ? dev_mem[dev_addr] : 16'hA5A5;

    task automatic chk(string rq, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic set_cfg(int cs, int ah, int gp, int rh, int wh, int rw, int ww,
                           int rd, int wd, int rec);
        cfg_sel   = 2'(cs);
        cfg_wdata = {4'(rec), 8'(wd), 8'(rd), 4'(ww), 4'(rw), 4'(wh), 4'(rh), 2'(gp), 1'(ah)};
        cfg_we    = 1'b1;
        @(negedge clk);
        cfg_we    = 1'b0;
        t_ah[cs] = ah; t_gap[cs] = gp; t_rh[cs] = rh; t_wh[cs] = wh; t_rw[cs] = rw;
        t_ww[cs] = ww; t_rd[cs] = rd; t_wd[cs] = wd; t_rec[cs] = rec;
    endtask

    // One access; counts pin cycles per falling edge until done.
    task automatic access(bit wr, int cs, logic [15:0] addr, logic [15:0] data);
        int pre = 0, csl = 0, advl = 0, drv = 0, oel = 0, wel = 0, whc = 0, pre_oe = -1;
        int rdy_bad = 0, badcs = 0, badbus = 0, n = 0, strb, e_rec, e_cs;
        bit cs_seen = 0, oe_seen = 0, we_seen = 0, timeout = 0;
        logic [15:0] exp_rd;
        chk("R9 ready before request", int'(req_ready), 1);
        e_rec = (last_rd && (cs != last_cs || wr)) ? t_rec[last_cs] : 0;
        strb  = wr ? t_ww[cs] + t_wd[cs] : t_rw[cs] + t_rd[cs];
        if (strb == 0) strb = 1;
        exp_rd = exp_mem[{cs[1:0], addr[3:0]}];
        req_valid = 1'b1; req_write = wr; req_cs = 2'(cs); req_addr = addr; req_wdata = data;
        forever begin
            @(negedge clk);
            if (n == 0) req_valid = 1'b0;
            n++;
            if (done) break;
            if (n > 3000) begin timeout = 1; break; end
            if (req_ready) rdy_bad++;
            if (&bus_cs_n) begin
                if (!cs_seen) pre++;
            end else begin
                cs_seen = 1;
                csl++;
                if (bus_cs_n != ~(4'b1 << cs)) badcs++;
                if (!bus_adv_n) begin
                    advl++;
                    if (bus_ad_out != addr || !bus_ad_oe) badbus++;
                end
                if (bus_ad_oe) drv++;
                if (!bus_oe_n) begin
                    if (!oe_seen) pre_oe = csl - 1;
                    oe_seen = 1;
                    oel++;
                end
                if (!bus_we_n) begin
                    we_seen = 1;
                    wel++;
                    if (bus_ad_out != data) badbus++;
                end else if (we_seen) begin
                    whc++;
                    if (bus_ad_out != data || !bus_ad_oe) badbus++;
                end
            end
        end
        chk("R8 access completes", int'(timeout), 0);
        chk(e_rec > 0 ? "R6 recovery cycles" : "R7 no recovery", pre, e_rec);
        chk("R2 single address strobe", advl, 1);
        chk("R11 chip select pattern", badcs, 0);
        chk("R2 bus values", badbus, 0);
        chk("R9 ready low during access", rdy_bad, 0);
        chk("R8 chip selects high at done", int'(&bus_cs_n), 1);
        chk("R9 ready with done", int'(req_ready), 1);
        if (wr) begin
            chk("R10 write chip select length", csl, 1 + t_ah[cs] + strb + t_wh[cs]);
            chk("R5 write drive cycles", drv, csl);
            chk("R4 write strobe length", wel, strb);
            chk("R5 write hold", whc, t_wh[cs]);
            chk("R3 no read strobe on write", oel, 0);
            exp_mem[{cs[1:0], addr[3:0]}] = data;
        end else begin
            chk("R10 read chip select length", csl, 1 + t_ah[cs] + t_gap[cs] + t_rh[cs] + strb);
            chk("R3 read drive cycles", drv, 1 + t_ah[cs]);
            chk("R3 chip select to read strobe", pre_oe, 1 + t_ah[cs] + t_gap[cs] + t_rh[cs]);
            chk("R4 read strobe length", oel, strb);
            chk("R5 no write strobe on read", wel, 0);
            chk("R8 read data", int'(rdata), int'(exp_rd));
        end
        last_rd = !wr;
        last_cs = cs;
        @(negedge clk);
        chk("R8 done lasts one cycle", int'(done), 0);
    endtask

    task automatic t_reset();
        chk("R1 chip selects idle", int'(bus_cs_n), 15);
        chk("R1 strobes idle", int'({bus_adv_n, bus_oe_n, bus_we_n}), 7);
        chk("R1 bus not driven", int'(bus_ad_oe), 0);
        chk("R1 ready", int'(req_ready), 1);
        chk("R1 no done", int'(done), 0);
    endtask

    // Reset timing words (R10): write delta 15, read delta 12, recovery 3.
    task automatic t_default();
        access(1, 0, 16'h0005, 16'h1234);
        access(0, 0, 16'h0005, 16'h0000);
        access(1, 3, 16'h0002, 16'hBEEF);
    endtask

    // Programmed word: address hold, read gap, holds and recovery orderings.
    task automatic t_programmed();
        set_cfg(1, 1, 2, 3, 2, 3, 2, 1, 0, 4);
        access(1, 1, 16'h0009, 16'hC0DE);
        access(0, 1, 16'h0009, 16'h0000);
        access(0, 1, 16'h0009, 16'h0000);
        access(1, 1, 16'h000A, 16'h5A5A);
        access(0, 1, 16'h000A, 16'h0000);
        access(0, 0, 16'h0005, 16'h0000);
        access(1, 1, 16'h0003, 16'h7777);
    endtask

    // All-zero word: one-cycle strobes (R4) and zero recovery.
    task automatic t_min_strobe();
        set_cfg(2, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        access(1, 2, 16'h000F, 16'h0F0F);
        access(0, 2, 16'h000F, 16'h0000);
        access(1, 2, 16'h0001, 16'h1111);
    endtask

    // Other chip selects keep their own words after reprogramming (R10).
    task automatic t_isolation();
        access(0, 3, 16'h0002, 16'h0000);
        access(0, 2, 16'h0001, 16'h0000);
        access(0, 0, 16'h0005, 16'h0000);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin exp_mem[i] = '0; dev_mem[i] = '0; end
        for (int i = 0; i < 4; i++) begin
            t_ah[i] = 0; t_gap[i] = 0; t_rh[i] = 0; t_wh[i] = 0; t_rw[i] = 0;
            t_ww[i] = 0; t_rd[i] = 12; t_wd[i] = 15; t_rec[i] = 3;
        end
        rst_n = 1'b0; req_valid = 0; req_write = 0; req_cs = 0; req_addr = 0;
        req_wdata = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = '0;
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_default();
        t_programmed();
        t_min_strobe();
        t_isolation();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // Watchdog: an expired run counts as a miscompare.
    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule